// File: doc/BRIEF.md
# AHB to APB Bridge

This block joins a pipelined, high-throughput AHB system bus to a simple APB peripheral bus. It answers as a slave on its AHB side and drives the APB side as the only master. For every accepted AHB transfer it latches the address and direction, decodes which of a few peripherals is targeted, and then runs exactly one APB transfer. While that transfer is in flight it holds the AHB data phase open by pulling its ready output low.

On the AHB side the address of one transfer overlaps the data phase of the one before it. The APB side never overlaps anything. The bridge converts between the two with a fixed sequence. First comes one decode cycle in which no peripheral is selected. Next is a setup cycle, where the select is high and the enable is low. Last is an access cycle, where the enable is high. That cycle returns read data and raises ready again. A new AHB address phase can be accepted during the access cycle, so back-to-back transfers chain with no idle cycle between them on the AHB side.

Top module: `ahb_apb_bridge`

## Requirements
- R1: After reset, `ahb_ready_out` is 1 and `apb_sel` and `apb_en` are 0.
- R2: A transfer is accepted when `ahb_sel` is 1, `ahb_trans` is NONSEQ (2'b10) or SEQ (2'b11), and `ahb_ready_in` is 1 at a clock edge while the bridge is ready. In the cycle after acceptance, `ahb_ready_out` is 0 and `apb_sel` is all zero. This is the decode cycle.
- R3: In the second cycle after acceptance (setup), exactly one `apb_sel` bit is high, `apb_en` is 0, `ahb_ready_out` is 0, and `apb_addr` and `apb_write` equal the accepted address and direction.
- R4: In the third cycle after acceptance (access), `apb_en` is 1, `apb_sel` keeps its setup value, and `ahb_ready_out` is 1. `apb_en` is never high while `apb_sel` is zero.
- R5: The active select bit is the one numbered by address bits [SEL_LSB+1:SEL_LSB] (bits 13:12 by default). Code 0 drives `apb_sel[0]` and code 3 drives `apb_sel[3]`.
- R6: Write data is taken from `ahb_wdata` in the decode cycle and is driven on `apb_wdata` through setup and access. Later changes to `ahb_wdata` have no effect on it.
- R7: In the access cycle of a read, `ahb_rdata` equals `apb_rdata`.
- R8: IDLE (2'b00) and BUSY (2'b01) transfers, and any transfer with `ahb_sel` low, start no APB activity. `ahb_ready_out` stays 1 for them, so they complete with zero wait states.
- R9: An address phase accepted in an access cycle starts its own decode cycle on the next edge. Transfers issued back to back each produce one full, separate APB transfer, in issue order.
- R10: `apb_addr`, `apb_write` and `apb_wdata` do not change between setup and access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ahb_sel | input | 1 | Slave select from the AHB address decoder |
| ahb_addr | input | 32 | AHB address (address phase) |
| ahb_trans | input | 2 | Transfer type: 00 IDLE, 01 BUSY, 10 NONSEQ, 11 SEQ |
| ahb_write | input | 1 | 1 for write, 0 for read (address phase) |
| ahb_wdata | input | 32 | AHB write data (data phase) |
| ahb_ready_in | input | 1 | Bus-wide ready, showing that the previous data phase ends |
| ahb_ready_out | output | 1 | Bridge ready; low inserts wait states |
| ahb_rdata | output | 32 | Read data returned to AHB |
| apb_sel | output | NUM_SEL | One-hot peripheral select |
| apb_en | output | 1 | APB enable (access cycle) |
| apb_addr | output | 32 | APB address |
| apb_write | output | 1 | APB direction |
| apb_wdata | output | 32 | APB write data |
| apb_rdata | input | 32 | Read data from the selected peripheral |

## Verification
Writes and reads are issued to each of the four select codes. This shows whether the decode picks the right line and whether data flows the right way for each direction. Back-to-back chains that mix reads, writes and SEQ types check the pipelined hand-over from one access cycle into the next decode cycle, as opposed to transfers issued with idle gaps. One write changes the AHB write data after the decode cycle, which tells a correct early capture apart from a live pass-through. IDLE, BUSY and unselected cycles confirm that non-transfers cost no wait state and raise no select.

// File: rtl/apbbr_pkg.sv
package apbbr_pkg;

    localparam int BR_ADDR_W = 32;
    localparam int BR_DATA_W = 32;

    typedef enum logic [1:0] {
        TR_IDLE   = 2'b00,
        TR_BUSY   = 2'b01,
        TR_NONSEQ = 2'b10,
        TR_SEQ    = 2'b11
    } trans_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_DECODE,
        PH_SETUP,
        PH_ACCESS
    } phase_e;

    typedef struct packed {
        logic [BR_ADDR_W-1:0] addr;
        logic                 write;
    } req_t;

    function automatic logic is_active(input logic [1:0] tr);
        return (tr == TR_NONSEQ) || (tr == TR_SEQ);
    endfunction

endpackage

// File: rtl/br_req_latch.sv
module br_req_latch
    import apbbr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 take_req,
    input  req_t                 req_in,
    input  logic                 take_data,
    input  logic [BR_DATA_W-1:0] data_in,
    output req_t                 req_q,
    output logic [BR_DATA_W-1:0] data_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            req_q  <= '0;
            data_q <= '0;
        end else begin
            if (take_req)
                req_q <= req_in;
            if (take_data)
                data_q <= data_in;
        end
    end
endmodule

// File: rtl/br_sel_decode.sv
module br_sel_decode
    import apbbr_pkg::*;
#(
    parameter int NUM_SEL = 4,
    parameter int SEL_LSB = 12
) (
    input  logic [BR_ADDR_W-1:0] addr,
    output logic [NUM_SEL-1:0]   onehot
);
    localparam int SEL_W = (NUM_SEL > 1) ? $clog2(NUM_SEL) : 1;

    logic [SEL_W-1:0] code;
    assign code = addr[SEL_LSB +: SEL_W];

    for (genvar i = 0; i < NUM_SEL; i++) begin : g_line
        assign onehot[i] = (code == SEL_W'(i));
    end
endmodule

// File: rtl/br_apb_seq.sv
module br_apb_seq
    import apbbr_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   take,
    output phase_e phase,
    output logic   ready
);
    phase_e nxt;

    always_comb begin
        nxt = phase;
        unique case (phase)
            PH_IDLE:   if (take) nxt = PH_DECODE;
            PH_DECODE: nxt = PH_SETUP;
            PH_SETUP:  nxt = PH_ACCESS;
            PH_ACCESS: nxt = take ? PH_DECODE : PH_IDLE;
            default:   nxt = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) phase <= PH_IDLE;
        else     phase <= nxt;
    end

    assign ready = (phase == PH_IDLE) || (phase == PH_ACCESS);
endmodule

// File: rtl/ahb_apb_bridge.sv
module ahb_apb_bridge
    import apbbr_pkg::*;
#(
    parameter int NUM_SEL = 4,
    parameter int SEL_LSB = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ahb_sel,
    input  logic [BR_ADDR_W-1:0] ahb_addr,
    input  logic [1:0]           ahb_trans,
    input  logic                 ahb_write,
    input  logic [BR_DATA_W-1:0] ahb_wdata,
    input  logic                 ahb_ready_in,
    output logic                 ahb_ready_out,
    output logic [BR_DATA_W-1:0] ahb_rdata,
    output logic [NUM_SEL-1:0]   apb_sel,
    output logic                 apb_en,
    output logic [BR_ADDR_W-1:0] apb_addr,
    output logic                 apb_write,
    output logic [BR_DATA_W-1:0] apb_wdata,
    input  logic [BR_DATA_W-1:0] apb_rdata
);
    phase_e             phase;
    logic               ready_int;
    logic               take;
    req_t               req_in;
    req_t               req_q;
    logic [NUM_SEL-1:0] sel_dec;

    assign take   = ahb_sel && is_active(ahb_trans) && ahb_ready_in && ready_int;
    assign req_in = '{addr: ahb_addr, write: ahb_write};

    br_apb_seq u_seq (
        .clk   (clk),
        .rst   (rst),
        .take  (take),
        .phase (phase),
        .ready (ready_int)
    );

    br_req_latch u_latch (
        .clk       (clk),
        .rst       (rst),
        .take_req  (take),
        .req_in    (req_in),
        .take_data (phase == PH_DECODE),
        .data_in   (ahb_wdata),
        .req_q     (req_q),
        .data_q    (apb_wdata)
    );

    br_sel_decode #(.NUM_SEL(NUM_SEL), .SEL_LSB(SEL_LSB)) u_dec (
        .addr   (req_q.addr),
        .onehot (sel_dec)
    );

    assign ahb_ready_out = ready_int;
    assign apb_sel   = (phase == PH_SETUP || phase == PH_ACCESS) ? sel_dec : '0;
    assign apb_en    = (phase == PH_ACCESS);
    assign apb_addr  = req_q.addr;
    assign apb_write = req_q.write;
    assign ahb_rdata = (phase == PH_ACCESS) ? apb_rdata : '0;

    // R1 state right after reset
    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (ahb_ready_out && apb_sel == '0 && !apb_en));

    // R2 decode cycle follows acceptance
    p_decode_wait_r2: assert property (@(posedge clk) disable iff (rst)
        (ahb_sel && is_active(ahb_trans) && ahb_ready_in && ahb_ready_out)
        |=> (!ahb_ready_out && apb_sel == '0));

    // R3 select is one-hot or idle
    p_sel_onehot_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(apb_sel));

    // R4 setup is always followed by access with the same select
    p_setup_access_r4: assert property (@(posedge clk) disable iff (rst)
        (apb_sel != '0 && !apb_en) |=> (apb_en && $stable(apb_sel) && ahb_ready_out));

    // R4 enable never without a select
    p_en_has_sel_r4: assert property (@(posedge clk) disable iff (rst)
        apb_en |-> (apb_sel != '0));

    // R10 and R6 address, direction and write data held into access
    p_hold_fields_r10: assert property (@(posedge clk) disable iff (rst)
        (apb_sel != '0 && !apb_en)
        |=> ($stable(apb_addr) && $stable(apb_write) && $stable(apb_wdata)));

    // R8 non-transfers in an idle bridge raise no select
    p_no_start_r8: assert property (@(posedge clk) disable iff (rst)
        (ahb_ready_out && !apb_en && !(ahb_sel && is_active(ahb_trans)))
        |=> (apb_sel == '0 && ahb_ready_out));
endmodule

// File: tb/ahb_apb_bridge_tb.sv
module ahb_apb_bridge_tb;
    import apbbr_pkg::*;

    localparam int NSEL = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ahb_sel = 1'b0;
    logic [31:0] ahb_addr = '0;
    logic [1:0]  ahb_trans = 2'b00;
    logic        ahb_write = 1'b0;
    logic [31:0] ahb_wdata = '0;
    logic        ahb_ready_out;
    logic [31:0] ahb_rdata;
    logic [NSEL-1:0] apb_sel;
    logic        apb_en;
    logic [31:0] apb_addr;
    logic        apb_write;
    logic [31:0] apb_wdata;
    logic [31:0] apb_rdata;

    int checks = 0;
    int failures = 0;
    logic done = 1'b0;

    always #4 clk = ~clk;

    function automatic logic [31:0] periph_data(input logic [31:0] a);
        return a ^ 32'h5A5A_C3C3;
    endfunction

    assign apb_rdata = periph_data(apb_addr);

    ahb_apb_bridge u_dut (
        .clk(clk), .rst(rst),
        .ahb_sel(ahb_sel), .ahb_addr(ahb_addr), .ahb_trans(ahb_trans),
        .ahb_write(ahb_write), .ahb_wdata(ahb_wdata),
        .ahb_ready_in(ahb_ready_out), .ahb_ready_out(ahb_ready_out),
        .ahb_rdata(ahb_rdata), .apb_sel(apb_sel), .apb_en(apb_en),
        .apb_addr(apb_addr), .apb_write(apb_write), .apb_wdata(apb_wdata),
        .apb_rdata(apb_rdata)
    );

    typedef struct {
        logic        w;
        logic [31:0] a;
        logic [31:0] d;
    } exp_t;

    exp_t sb[$];

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Driver: called at a negedge; issues an address phase and waits for acceptance.
    task automatic issue(input logic w, input logic [31:0] a, input logic [31:0] d,
                         input logic [1:0] tr, input bit scramble);
        exp_t e;
        ahb_sel = 1'b1; ahb_trans = tr; ahb_addr = a; ahb_write = w;
        while (!ahb_ready_out) @(negedge clk);
        e.w = w; e.a = a; e.d = d;
        sb.push_back(e);
        @(negedge clk);
        ahb_wdata = d;
        ahb_sel = 1'b0; ahb_trans = TR_IDLE;
        // R2 decode cycle: waiting, nothing selected
        check(!ahb_ready_out, "R2 ready low", {31'b0, ahb_ready_out}, 32'h0);
        check(apb_sel == '0, "R2 no select", {28'b0, apb_sel}, 32'h0);
        if (scramble) begin
            @(negedge clk);
            ahb_wdata = ~d;
        end
    endtask

    task automatic drain();
        ahb_sel = 1'b0; ahb_trans = TR_IDLE;
        while (!(ahb_ready_out && sb.size() == 0)) @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && apb_sel != '0) begin
            if (sb.size() == 0) begin
                check(1'b0, "R9 unexpected APB transfer", apb_addr, 32'h0);
            end else begin
                exp_t e;
                logic [NSEL-1:0] es;
                e = sb[0];
                es = NSEL'(1) << e.a[13:12];
                check(apb_sel == es, "R5 select line", {28'b0, apb_sel}, {28'b0, es});
                check(apb_addr == e.a, "R3 address", apb_addr, e.a);
                check(apb_write == e.w, "R3 direction", {31'b0, apb_write}, {31'b0, e.w});
                if (e.w)
                    check(apb_wdata == e.d, "R6 write data", apb_wdata, e.d);
                if (!apb_en) begin
                    check(!ahb_ready_out, "R3 ready low in setup", {31'b0, ahb_ready_out}, 32'h0);
                end else begin
                    check(ahb_ready_out, "R4 ready high in access", {31'b0, ahb_ready_out}, 32'h1);
                    if (!e.w)
                        check(ahb_rdata == periph_data(e.a), "R7 read data", ahb_rdata, periph_data(e.a));
                    void'(sb.pop_front());
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(ahb_ready_out && apb_sel == '0 && !apb_en, "R1 reset state",
              {27'b0, ahb_ready_out, apb_sel}, 32'h10);

        // R8: idle, busy, unselected non-transfers
        ahb_sel = 1'b1; ahb_trans = TR_IDLE; ahb_addr = 32'h4000_1000;
        @(negedge clk);
        check(ahb_ready_out && apb_sel == '0, "R8 idle transfer", {31'b0, ahb_ready_out}, 32'h1);
        ahb_trans = TR_BUSY;
        @(negedge clk);
        check(ahb_ready_out && apb_sel == '0, "R8 busy transfer", {31'b0, ahb_ready_out}, 32'h1);
        ahb_sel = 1'b0; ahb_trans = TR_NONSEQ;
        @(negedge clk);
        @(negedge clk);
        check(ahb_ready_out && apb_sel == '0, "R8 unselected", {28'b0, apb_sel}, 32'h0);
        ahb_trans = TR_IDLE;

        // R5, R6, R7: isolated writes then reads to every select code
        for (int i = 0; i < NSEL; i++) begin
            issue(1'b1, 32'h4000_0000 | (i << 12) | (i * 4), 32'hA000_0000 + i, TR_NONSEQ, 1'b0);
            drain();
        end
        for (int i = 0; i < NSEL; i++) begin
            issue(1'b0, 32'h4000_0040 | (i << 12), 32'h0, TR_NONSEQ, 1'b0);
            drain();
        end

        // R6: AHB write data changes after the decode cycle
        issue(1'b1, 32'h4000_2010, 32'hCAFE_F00D, TR_NONSEQ, 1'b1);
        drain();

        // R9: back-to-back mixed chain, NONSEQ then SEQ
        issue(1'b1, 32'h4000_3000, 32'h1111_0001, TR_NONSEQ, 1'b0);
        issue(1'b0, 32'h4000_1004, 32'h0,         TR_SEQ,    1'b0);
        issue(1'b1, 32'h4000_0008, 32'h3333_0003, TR_SEQ,    1'b0);
        issue(1'b0, 32'h4000_200C, 32'h0,         TR_SEQ,    1'b0);
        issue(1'b1, 32'h4000_3010, 32'h5555_0005, TR_NONSEQ, 1'b1);
        drain();
        check(sb.size() == 0, "R9 all transfers completed", sb.size(), 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule